// File: doc/BRIEF.md
# Write-Through Mirror Buffer

This block sits between a fast local processor bus and a much slower host memory bus. Every store on the fast side is checked against a software-selected mirroring policy. Stores that land in a mirrored window are copied to host memory so that the host's video hardware and peripherals see the same contents as the fast local memory.

A copied store is parked in a one-entry posted-write buffer. The fast side finishes the store at once. The buffer then presents the byte on the host write handshake until the host clock-enable strobe accepts it. The fast side is stalled only when a second mirrored store arrives while the first is still waiting.

The host timing is modelled as an enable pulse in the same clock domain. A host write completes on any cycle in which `host_wr` and `host_strobe` are both high at the rising clock edge.

Top module: `mirror_wbuf`

## Requirements
- R1: The two-bit policy register (`cfg_mode`) uses these codes: 0 mirrors all memory, 1 the text screen, 2 the graphics screen, 3 nothing. Reset loads 0. A write with `cfg_we` high loads `cfg_wdata` at the clock edge, and the new value is readable on `cfg_mode` after that edge.
- R2: While `io_visible` is high, a store to 0xD000–0xDFFF is mirrored under every policy, including policy 3. While `io_visible` is low, that range is ordinary memory and follows the policy.
- R3: Policy 1 mirrors 0x0400–0x07FF. Colour memory 0xD800–0xDBFF is mirrored only through the I/O rule of R2, so only while `io_visible` is high.
- R4: Policy 2 mirrors 0x8C00–0x8FFF and 0xA000–0xBFFF and nothing else outside the I/O rule.
- R5: A store that is not mirrored under the current policy never raises `host_wr` and never stalls, even while the buffer is full.
- R6: When the buffer is empty, a mirrored store is accepted in its own cycle with `st_stall` low. From the next cycle, `host_wr` is high with `host_addr` and `host_data` equal to that store.
- R7: When the buffer is full and `host_strobe` is low, a mirrored store raises `st_stall` in that cycle and is not accepted. The pending address and data stay unchanged.
- R8: The pending byte is written at the first edge where `host_strobe` is high. `host_wr` falls after that edge unless a new store is captured at the same edge. A mirrored store that meets a draining buffer is accepted without a stall.
- R9: After reset the buffer is empty: `host_wr` and `st_stall` are low.
- R10: A policy write and a store in the same cycle are decoded under the old policy. The new policy applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Fast-side store request |
| st_addr | input | 16 | Store address |
| st_data | input | 8 | Store data |
| st_stall | output | 1 | Store not accepted this cycle; hold it |
| cfg_we | input | 1 | Policy register write enable |
| cfg_wdata | input | 2 | Policy code to write |
| cfg_mode | output | 2 | Current policy code |
| io_visible | input | 1 | I/O space is mapped in |
| host_strobe | input | 1 | Host clock-enable pulse |
| host_wr | output | 1 | Pending host write present |
| host_addr | output | 16 | Host write address |
| host_data | output | 8 | Host write data |

## Verification
The assertions assume that a stalled store is held by the fast side with the same address and data until it is accepted. They also assume that `host_strobe` is a plain enable that may arrive in any cycle, including the cycle of a capture.

The stimulus follows both assumptions. Every stalled store is repeated unchanged on the following cycles, and strobes are raised only at chosen points: while the buffer is empty, while it is full, and in the same cycle as a competing store. The address sweep covers the first and last byte of every 256-byte page under all four policies and both I/O settings, so every window edge is crossed.

// File: rtl/mirror_pkg.sv
package mirror_pkg;

  typedef enum logic [1:0] {
    MIR_ALL  = 2'd0,
    MIR_TEXT = 2'd1,
    MIR_GFX  = 2'd2,
    MIR_NONE = 2'd3
  } mir_mode_e;

  // Inclusive window test on widened addresses.
  function automatic logic in_window(input int unsigned a,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Policy decision for an address that is not an I/O hit.
  function automatic logic policy_hit(input mir_mode_e m,
                                      input logic txt_hit,
                                      input logic gfx_hit);
    logic r;
    case (m)
      MIR_ALL:  r = 1'b1;
      MIR_TEXT: r = txt_hit;
      MIR_GFX:  r = gfx_hit;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mirror_mode_reg.sv
module mirror_mode_reg
  import mirror_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [1:0] wdata,
  output mir_mode_e mode
);

  always_ff @(posedge clk) begin
    if (!rst_n)  mode <= MIR_ALL;
    else if (we) mode <= mir_mode_e'(wdata);
  end

endmodule

// File: rtl/mirror_region_dec.sv
module mirror_region_dec
  import mirror_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned IO_LO  = 32'hD000,
  parameter int unsigned IO_HI  = 32'hDFFF,
  parameter int unsigned TXT_LO = 32'h0400,
  parameter int unsigned TXT_HI = 32'h07FF,
  parameter int unsigned BMP_LO = 32'hA000,
  parameter int unsigned BMP_HI = 32'hBFFF,
  parameter int unsigned CMX_LO = 32'h8C00,
  parameter int unsigned CMX_HI = 32'h8FFF
) (
  input  mir_mode_e         mode,
  input  logic              io_visible,
  input  logic [ADDR_W-1:0] addr,
  output logic              io_hit,
  output logic              mirrored
);

  localparam int PAD_W = 32 - ADDR_W;

  int unsigned a_w;
  logic txt_hit, gfx_hit;

  always_comb begin
    a_w      = {{PAD_W{1'b0}}, addr};
    io_hit   = io_visible && in_window(a_w, IO_LO, IO_HI);
    txt_hit  = in_window(a_w, TXT_LO, TXT_HI);
    gfx_hit  = in_window(a_w, BMP_LO, BMP_HI) || in_window(a_w, CMX_LO, CMX_HI);
    mirrored = io_hit || policy_hit(mode, txt_hit, gfx_hit);
  end

endmodule

// File: rtl/mirror_post_buf.sv
module mirror_post_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              st_mirrored,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              host_strobe,
  output logic              st_stall,
  output logic              capture,
  output logic              drain,
  output logic              host_wr,
  output logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_data
);

  logic full;

  always_comb begin
    drain    = full && host_strobe;
    st_stall = st_valid && st_mirrored && full && !drain;
    capture  = st_valid && st_mirrored && !st_stall;
    host_wr  = full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      host_addr <= '0;
      host_data <= '0;
    end else begin
      if (capture) begin
        full      <= 1'b1;
        host_addr <= st_addr;
        host_data <= st_data;
      end else if (drain) begin
        full <= 1'b0;
      end
    end
  end

  assert_capture_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> host_wr && host_addr == $past(st_addr) && host_data == $past(st_data));

  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_strobe |=> host_wr && $stable(host_addr) && $stable(host_data));

  assert_stall_keeps_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |=> host_wr);

  assert_drain_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !capture |=> !host_wr);

endmodule

// File: rtl/mirror_wbuf.sv
module mirror_wbuf
  import mirror_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_stall,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_mode,
  input  logic              io_visible,
  input  logic              host_strobe,
  output logic              host_wr,
  output logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_data
);

  mir_mode_e mode;
  logic      io_hit, mirrored, capture, drain;

  mirror_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .mode  (mode)
  );

  mirror_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .mode       (mode),
    .io_visible (io_visible),
    .addr       (st_addr),
    .io_hit     (io_hit),
    .mirrored   (mirrored)
  );

  mirror_post_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_mirrored (mirrored),
    .st_addr     (st_addr),
    .st_data     (st_data),
    .host_strobe (host_strobe),
    .st_stall    (st_stall),
    .capture     (capture),
    .drain       (drain),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_data   (host_data)
  );

  assign cfg_mode = mode;

  assert_none_only_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture && mode == MIR_NONE |=> host_wr && host_addr[ADDR_W-1 -: 4] == 4'hD);

  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_mode == $past(cfg_wdata));

  assert_reset_empty_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> !host_wr && !st_stall);

  assert_write_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !capture && host_strobe |=> !host_wr);

endmodule

// File: tb/mirror_wbuf_tb.sv
module mirror_wbuf_tb;

  logic        clk = 0;
  logic        rst_n;
  logic        st_valid;
  logic [15:0] st_addr;
  logic [7:0]  st_data;
  logic        st_stall;
  logic        cfg_we;
  logic [1:0]  cfg_wdata;
  logic [1:0]  cfg_mode;
  logic        io_visible;
  logic        host_strobe;
  logic        host_wr;
  logic [15:0] host_addr;
  logic [7:0]  host_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mirror_wbuf u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_stall(st_stall), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_mode(cfg_mode), .io_visible(io_visible),
    .host_strobe(host_strobe), .host_wr(host_wr), .host_addr(host_addr),
    .host_data(host_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_mir(input int mode, input bit iov, input int a);
    if (iov && a >= 'hD000 && a <= 'hDFFF) return 1;
    case (mode)
      0: return 1;
      1: return a >= 'h0400 && a <= 'h07FF;
      2: return (a >= 'hA000 && a <= 'hBFFF) || (a >= 'h8C00 && a <= 'h8FFF);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int mode, input bit iov, input int a);
    if (iov && a >= 'hD000 && a <= 'hDFFF) return "R2";
    case (mode)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    cfg_we = 1; cfg_wdata = 2'(m);
    step();
    cfg_we = 0;
    #1 chk(cfg_mode == 2'(m), "R1", "mode readback", cfg_mode, m);
  endtask

  task automatic drain_now;
    host_strobe = 1;
    step();
    host_strobe = 0;
    #1 chk(host_wr == 0, "R8", "empty after strobe", host_wr, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; cfg_we = 0;
    cfg_wdata = 0; io_visible = 0; host_strobe = 0;
    repeat (3) step();
    rst_n = 1;
    #1;
    chk(host_wr == 0, "R9", "host_wr after reset", host_wr, 0);
    chk(st_stall == 0, "R9", "stall after reset", st_stall, 0);
    chk(cfg_mode == 0, "R1", "reset policy", cfg_mode, 0);

    // Sweep: every policy, both I/O settings, both ends of every page.
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      set_mode(m);
      for (int iv = 0; iv < 2; iv++) begin
        io_visible = iv[0];
        for (int pg = 0; pg < 256; pg++) begin
          for (int k = 0; k < 2; k++) begin
            int a;
            bit e;
            a = pg * 256 + k * 255;
            e = exp_mir(m, iv[0], a);
            st_valid = 1; st_addr = 16'(a); st_data = 8'((a * 7 + m) & 255);
            #1 chk(st_stall == 0, "R6", "no stall on empty buffer", st_stall, 0);
            step();
            st_valid = 0;
            #1 chk(host_wr == e, tag_of(m, iv[0], a), "mirror decision", host_wr, e);
            if (host_wr) begin
              chk(host_addr == 16'(a), "R6", "host address", host_addr, a);
              chk(host_data == 8'((a * 7 + m) & 255), "R6", "host data",
                  host_data, (a * 7 + m) & 255);
              drain_now();
            end
          end
        end
      end
    end

    // Stall and same-cycle drain/accept, policy all.
    set_mode(0);
    io_visible = 0;
    st_valid = 1; st_addr = 16'h2000; st_data = 8'h11;
    step();
    st_addr = 16'h3000; st_data = 8'h22;
    #1 chk(st_stall == 1, "R7", "stall on full buffer", st_stall, 1);
    step();
    #1 chk(st_stall == 1, "R7", "stall held", st_stall, 1);
    chk(host_addr == 16'h2000, "R7", "pending addr held", host_addr, 'h2000);
    chk(host_data == 8'h11, "R7", "pending data held", host_data, 'h11);
    host_strobe = 1;
    #1 chk(st_stall == 0, "R8", "accept during drain", st_stall, 0);
    step();
    st_valid = 0; host_strobe = 0;
    #1 chk(host_wr == 1, "R8", "refilled after drain", host_wr, 1);
    chk(host_addr == 16'h3000, "R8", "new pending addr", host_addr, 'h3000);
    chk(host_data == 8'h22, "R8", "new pending data", host_data, 'h22);
    drain_now();

    // Strobe with empty buffer does nothing.
    host_strobe = 1;
    step();
    host_strobe = 0;
    #1 chk(host_wr == 0, "R8", "strobe on empty", host_wr, 0);

    // Non-mirrored store while full: policy none, I/O store pending.
    set_mode(3);
    io_visible = 1;
    st_valid = 1; st_addr = 16'hD020; st_data = 8'h5A;
    step();
    st_addr = 16'h1000; st_data = 8'hA5;
    #1 chk(st_stall == 0, "R5", "unmirrored store not stalled", st_stall, 0);
    step();
    st_valid = 0;
    #1 chk(host_addr == 16'hD020, "R5", "pending untouched", host_addr, 'hD020);
    chk(host_data == 8'h5A, "R5", "pending data untouched", host_data, 'h5A);
    drain_now();

    // Policy write in same cycle as store: old policy applies (R10).
    set_mode(0);
    io_visible = 0;
    cfg_we = 1; cfg_wdata = 2'd3;
    st_valid = 1; st_addr = 16'h1234; st_data = 8'h77;
    step();
    cfg_we = 0;
    st_valid = 0;
    #1 chk(host_wr == 1, "R10", "old policy used", host_wr, 1);
    drain_now();
    st_valid = 1; st_addr = 16'h1235; st_data = 8'h78;
    step();
    st_valid = 0;
    #1 chk(host_wr == 0, "R10", "new policy used", host_wr, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule